// File: doc/BRIEF.md
# Coherent Read Sequencer (Slave Side)

This block serves a single coherent master on the slave end of a read interface. The master sends read requests and cache-management requests. For requests that give the master exclusive rights, the sequencer first sends a probe to every peer agent and waits until each peer reports completion. It then returns a response that holds either a line of data with its coherency status, an error, or a plain success. It accepts no further request until the master acknowledges that response.

Backing storage is a small read-only line array, laid out so that it maps onto block RAM. A parameterised address window decides which addresses are backed. The acknowledge and probe-completion streams always accept, so the lower-priority request stream can never stall them.

Top module: `coh_rd_seq`

## Requirements
- R1: Every stream transfers only in a cycle where its valid and ready are both high. After reset `rdcmd_ready` is 1 and `rdrsp_valid` and every `prbcmd_valid` bit are 0. `rdcmd_ready` is 1 only while the sequencer is idle, and it drops in the cycle after a request is accepted.
- R2: Request codes on `rdcmd_kind` are: 0 shared read, 1 unique read, 2 one-time read, 3 make-unique, 4 barrier, 5 to 7 unknown. Response codes on `rdrsp_kind` are: 0 success, 1 data, 2 error.
- R3: A shared read or a one-time read whose address lies in the window `MEM_BASE` to `MEM_BASE+MEM_DEPTH-1` sends no probe. It returns kind 1 with status 4'b0001 and the line at index `addr-MEM_BASE`.
- R4: A unique read in the window probes every peer, then returns kind 1 with status 4'b0011 and the line data.
- R5: Make-unique probes every peer at any address, then returns kind 0 with data 0 and status 0.
- R6: Barrier returns kind 0 with data 0 and status 0 and sends no probe.
- R7: A data-carrying request outside the window, or an unknown code, returns kind 2 with data 0 and status 0 and sends no probe.
- R8: Each peer's probe request stays valid until that peer accepts it. The response waits until every peer has sent one completion after accepting its probe. A completion that arrives while no probe is outstanding is ignored.
- R9: While `rdrsp_valid` is high and `rdrsp_ready` is low, the response kind, data and status hold steady.
- R10: After the response transfers, `rdcmd_ready` stays 0 until an acknowledge transfers, and it returns to 1 in the next cycle. An acknowledge sent while no response awaits one has no effect.
- R11: `rdack_ready` and every `prbrsp_ready` bit are 1 in every cycle after reset.
- R12: The line at index i holds the low `DATA_W` bits of (i * 32'h9E3779B1) XOR 32'h5A5AC3C3. Status bit 0 means valid, bit 1 unique, bit 2 owner and bit 3 dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdcmd_valid | input | 1 | Request valid |
| rdcmd_ready | output | 1 | Request ready (idle) |
| rdcmd_kind | input | 3 | Request code |
| rdcmd_addr | input | ADDR_W | Line address |
| rdrsp_valid | output | 1 | Response valid |
| rdrsp_ready | input | 1 | Response ready |
| rdrsp_kind | output | 2 | Response code |
| rdrsp_data | output | DATA_W | Line data, 0 when no data |
| rdrsp_status | output | 4 | Coherency status |
| rdack_valid | input | 1 | Master acknowledge valid |
| rdack_ready | output | 1 | Acknowledge ready |
| prbcmd_valid | output | N_PEERS | Probe request valid, one per peer |
| prbcmd_ready | input | N_PEERS | Probe request ready, one per peer |
| prbcmd_addr | output | ADDR_W | Address being probed |
| prbrsp_valid | input | N_PEERS | Probe completion valid, one per peer |
| prbrsp_ready | output | N_PEERS | Probe completion ready, one per peer |

## Verification
The assertions check on every cycle these stream rules: the response and the pending probes hold steady while stalled, no probe overlaps a response, requests are locked out from acceptance until the acknowledge, and responses without data carry zeros. Only the bench scenarios can show that each request code yields the right response kind, status and line contents. The same holds for whether the probe count matches the request, what happens at the window edges, and that stray completions and acknowledges are ignored.

// File: rtl/coh_rd_pkg.sv
package coh_rd_pkg;

  localparam logic [2:0] CMD_RD_SHARED = 3'd0;
  localparam logic [2:0] CMD_RD_UNIQUE = 3'd1;
  localparam logic [2:0] CMD_RD_ONCE   = 3'd2;
  localparam logic [2:0] CMD_MK_UNIQUE = 3'd3;
  localparam logic [2:0] CMD_BARRIER   = 3'd4;

  localparam logic [1:0] RSP_SUCCESS = 2'd0;
  localparam logic [1:0] RSP_DATA    = 2'd1;
  localparam logic [1:0] RSP_ERROR   = 2'd2;

  // coherency status bit positions
  localparam int ST_VALID  = 0;
  localparam int ST_UNIQUE = 1;
  localparam int ST_OWNER  = 2;
  localparam int ST_DIRTY  = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROBE,
    S_FETCH,
    S_RSP,
    S_ACK
  } seq_state_e;

  typedef struct packed {
    logic       need_probe;
    logic       has_data;
    logic [1:0] kind;
    logic [3:0] status;
  } rsp_plan_t;

endpackage

// File: rtl/coh_rd_decode.sv
module coh_rd_decode
  import coh_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_BASE  = 64,
  parameter int MEM_DEPTH = 32,
  parameter int IDX_W     = 5
) (
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  output rsp_plan_t         plan,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0] LO_V = (ADDR_W+1)'(MEM_BASE);
  localparam logic [ADDR_W:0] HI_V = (ADDR_W+1)'(MEM_BASE + MEM_DEPTH - 1);

  logic              in_range;
  logic [ADDR_W-1:0] offset;
  rsp_plan_t         data_plan;
  rsp_plan_t         err_plan;

  assign in_range = ({1'b0, addr} >= LO_V) && ({1'b0, addr} <= HI_V);
  assign offset   = addr - ADDR_W'(MEM_BASE);
  assign idx      = offset[IDX_W-1:0];

  always_comb begin
    err_plan            = '0;
    err_plan.kind       = RSP_ERROR;
    data_plan           = '0;
    data_plan.has_data  = 1'b1;
    data_plan.kind      = RSP_DATA;
    data_plan.status[ST_VALID] = 1'b1;

    plan = err_plan;
    unique case (kind)
      CMD_RD_SHARED, CMD_RD_ONCE: plan = in_range ? data_plan : err_plan;
      CMD_RD_UNIQUE: begin
        if (in_range) begin
          plan                    = data_plan;
          plan.need_probe         = 1'b1;
          plan.status[ST_UNIQUE]  = 1'b1;
        end
      end
      CMD_MK_UNIQUE: begin
        plan            = '0;
        plan.need_probe = 1'b1;
        plan.kind       = RSP_SUCCESS;
      end
      CMD_BARRIER: begin
        plan      = '0;
        plan.kind = RSP_SUCCESS;
      end
      default: plan = err_plan;
    endcase
  end

endmodule

// File: rtl/coh_rd_probe.sv
module coh_rd_probe #(
  parameter int N_PEERS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [N_PEERS-1:0] prb_valid,
  input  logic [N_PEERS-1:0] prb_ready,
  input  logic [N_PEERS-1:0] done_valid,
  output logic [N_PEERS-1:0] done_ready,
  output logic               all_done
);

  logic [N_PEERS-1:0] pend_q;
  logic [N_PEERS-1:0] sent_q;
  logic [N_PEERS-1:0] done_q;

  for (genvar p = 0; p < N_PEERS; p++) begin : g_peer
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[p] <= 1'b0;
        sent_q[p] <= 1'b0;
        done_q[p] <= 1'b0;
      end else if (start) begin
        pend_q[p] <= 1'b1;
        sent_q[p] <= 1'b0;
        done_q[p] <= 1'b0;
      end else begin
        if (pend_q[p] && prb_ready[p]) begin
          pend_q[p] <= 1'b0;
          sent_q[p] <= 1'b1;
        end
        if (sent_q[p] && done_valid[p]) begin
          done_q[p] <= 1'b1;
        end
      end
    end
  end

  assign prb_valid  = pend_q;
  assign done_ready = '1;
  assign all_done   = &done_q;

endmodule

// File: rtl/coh_rd_line_rom.sv
module coh_rd_line_rom #(
  parameter int DATA_W    = 32,
  parameter int MEM_DEPTH = 32,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] lines [MEM_DEPTH];

  function automatic logic [DATA_W-1:0] line_word(input int i);
    logic [31:0] w;
    w = (32'(i) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    return DATA_W'(w);
  endfunction

  initial begin
    for (int i = 0; i < MEM_DEPTH; i++) lines[i] = line_word(i);
  end

  always_ff @(posedge clk) begin
    q <= lines[idx];
  end

endmodule

// File: rtl/coh_rd_seq.sv
module coh_rd_seq
  import coh_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int N_PEERS   = 2,
  parameter int MEM_BASE  = 64,
  parameter int MEM_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rdcmd_valid,
  output logic               rdcmd_ready,
  input  logic [2:0]         rdcmd_kind,
  input  logic [ADDR_W-1:0]  rdcmd_addr,
  output logic               rdrsp_valid,
  input  logic               rdrsp_ready,
  output logic [1:0]         rdrsp_kind,
  output logic [DATA_W-1:0]  rdrsp_data,
  output logic [3:0]         rdrsp_status,
  input  logic               rdack_valid,
  output logic               rdack_ready,
  output logic [N_PEERS-1:0] prbcmd_valid,
  input  logic [N_PEERS-1:0] prbcmd_ready,
  output logic [ADDR_W-1:0]  prbcmd_addr,
  input  logic [N_PEERS-1:0] prbrsp_valid,
  output logic [N_PEERS-1:0] prbrsp_ready
);

  localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  seq_state_e        state_q;
  rsp_plan_t         plan_d, plan_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              probe_start;
  logic              probes_done;
  logic [DATA_W-1:0] rom_q;

  coh_rd_decode #(
    .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .MEM_DEPTH(MEM_DEPTH), .IDX_W(IDX_W)
  ) u_decode (
    .kind(rdcmd_kind),
    .addr(rdcmd_addr),
    .plan(plan_d),
    .idx (idx_d)
  );

  coh_rd_probe #(.N_PEERS(N_PEERS)) u_probe (
    .clk       (clk),
    .rst       (rst),
    .start     (probe_start),
    .prb_valid (prbcmd_valid),
    .prb_ready (prbcmd_ready),
    .done_valid(prbrsp_valid),
    .done_ready(prbrsp_ready),
    .all_done  (probes_done)
  );

  coh_rd_line_rom #(
    .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .IDX_W(IDX_W)
  ) u_rom (
    .clk(clk),
    .idx(idx_q),
    .q  (rom_q)
  );

  assign rdcmd_ready = (state_q == S_IDLE);
  assign accept      = rdcmd_valid && rdcmd_ready;
  assign probe_start = accept && plan_d.need_probe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      plan_q  <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            plan_q  <= plan_d;
            idx_q   <= idx_d;
            addr_q  <= rdcmd_addr;
            state_q <= plan_d.need_probe ? S_PROBE : S_FETCH;
          end
        end
        S_PROBE: if (probes_done) state_q <= S_FETCH;
        S_FETCH: state_q <= S_RSP;
        S_RSP:   if (rdrsp_ready) state_q <= S_ACK;
        S_ACK:   if (rdack_valid) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rdrsp_valid  = (state_q == S_RSP);
  assign rdrsp_kind   = plan_q.kind;
  assign rdrsp_status = plan_q.status;
  assign rdrsp_data   = plan_q.has_data ? rom_q : '0;
  assign rdack_ready  = 1'b1;
  assign prbcmd_addr  = addr_q;

endmodule

// File: rtl/coh_rd_seq_chk.sv
module coh_rd_seq_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int N_PEERS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               rdcmd_valid,
  input logic               rdcmd_ready,
  input logic               rdrsp_valid,
  input logic               rdrsp_ready,
  input logic [1:0]         rdrsp_kind,
  input logic [DATA_W-1:0]  rdrsp_data,
  input logic [3:0]         rdrsp_status,
  input logic [N_PEERS-1:0] prbcmd_valid,
  input logic [N_PEERS-1:0] prbcmd_ready
);

  // R1
  cmd_lock_chk: assert property (@(posedge clk) disable iff (rst)
    rdcmd_valid && rdcmd_ready |=> !rdcmd_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdrsp_valid && !rdrsp_ready |=> rdrsp_valid && $stable(rdrsp_kind)
      && $stable(rdrsp_data) && $stable(rdrsp_status));

  // R8
  prb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(prbcmd_valid & ~prbcmd_ready)) |=>
      ((prbcmd_valid & $past(prbcmd_valid & ~prbcmd_ready))
        == $past(prbcmd_valid & ~prbcmd_ready)));

  // R4
  prb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (|prbcmd_valid) |-> !rdrsp_valid && !rdcmd_ready);

  // R7
  nodata_chk: assert property (@(posedge clk) disable iff (rst)
    rdrsp_valid && rdrsp_kind != 2'd1 |-> rdrsp_data == '0 && rdrsp_status == 4'd0);

  // R3
  data_status_chk: assert property (@(posedge clk) disable iff (rst)
    rdrsp_valid && rdrsp_kind == 2'd1 |-> rdrsp_status[0] && rdrsp_status[3:2] == 2'b00);

  // R10
  ack_wait_chk: assert property (@(posedge clk) disable iff (rst)
    rdrsp_valid && rdrsp_ready |=> !rdcmd_ready && !rdrsp_valid);

endmodule

bind coh_rd_seq coh_rd_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PEERS(N_PEERS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rdcmd_valid (rdcmd_valid),
  .rdcmd_ready (rdcmd_ready),
  .rdrsp_valid (rdrsp_valid),
  .rdrsp_ready (rdrsp_ready),
  .rdrsp_kind  (rdrsp_kind),
  .rdrsp_data  (rdrsp_data),
  .rdrsp_status(rdrsp_status),
  .prbcmd_valid(prbcmd_valid),
  .prbcmd_ready(prbcmd_ready)
);

// File: tb/coh_rd_seq_tb.sv
`timescale 1ns/1ps
module coh_rd_seq_tb;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NP     = 2;
  localparam int BASE   = 64;
  localparam int DEPTH  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rdcmd_valid = 1'b0;
  logic              rdcmd_ready;
  logic [2:0]        rdcmd_kind = '0;
  logic [ADDR_W-1:0] rdcmd_addr = '0;
  logic              rdrsp_valid;
  logic              rdrsp_ready = 1'b0;
  logic [1:0]        rdrsp_kind;
  logic [DATA_W-1:0] rdrsp_data;
  logic [3:0]        rdrsp_status;
  logic              rdack_valid = 1'b0;
  logic              rdack_ready;
  logic [NP-1:0]     prbcmd_valid;
  logic [NP-1:0]     prbcmd_ready = '0;
  logic [ADDR_W-1:0] prbcmd_addr;
  logic [NP-1:0]     prbrsp_valid = '0;
  logic [NP-1:0]     prbrsp_ready;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  bit  stray_req = 1'b0;
  int  acc_cnt [NP];
  int  rsp_cnt [NP];
  int  cd      [NP];
  bit  busy    [NP];
  bit  hs_prev [NP];

  always #2.5 clk = ~clk;

  coh_rd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PEERS(NP), .MEM_BASE(BASE), .MEM_DEPTH(DEPTH)
  ) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] line_word(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  // expected: {probe, kind, status, data}
  function automatic logic [38:0] expect_rsp(input logic [2:0] k, input logic [7:0] a);
    bit inr;
    logic [31:0] d;
    inr = (int'(a) >= BASE) && (int'(a) < BASE + DEPTH);
    d = line_word(int'(a) - BASE);
    case (k)
      3'd0, 3'd2: return inr ? {1'b0, 2'd1, 4'b0001, d} : {1'b0, 2'd2, 4'd0, 32'd0};
      3'd1:       return inr ? {1'b1, 2'd1, 4'b0011, d} : {1'b0, 2'd2, 4'd0, 32'd0};
      3'd3:       return {1'b1, 2'd0, 4'd0, 32'd0};
      3'd4:       return {1'b0, 2'd0, 4'd0, 32'd0};
      default:    return {1'b0, 2'd2, 4'd0, 32'd0};
    endcase
  endfunction

  // peer model: random accept, random completion delay
  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      prbrsp_valid[p] = 1'b0;
      if (rst) begin
        acc_cnt[p] = 0; rsp_cnt[p] = 0; busy[p] = 0; hs_prev[p] = 0; cd[p] = 0;
        prbcmd_ready[p] = 1'b0;
      end else begin
        if (hs_prev[p]) begin
          acc_cnt[p]++;
          busy[p] = 1'b1;
          cd[p] = $urandom % 5;
        end else if (busy[p]) begin
          if (cd[p] == 0) begin
            prbrsp_valid[p] = 1'b1;
            rsp_cnt[p]++;
            busy[p] = 1'b0;
          end else cd[p]--;
        end else if (stray_req) begin
          prbrsp_valid[p] = 1'b1;
        end
        prbcmd_ready[p] = ($urandom % 3) != 0;
        hs_prev[p] = prbcmd_valid[p] && prbcmd_ready[p];
      end
    end
  end

  task automatic run_tx(input logic [2:0] k, input logic [7:0] a, input int rwait, input int await_n);
    logic [38:0] e;
    int  ab [NP];
    int  rb [NP];
    bit  stable_ok;
    bit  lock_ok;
    logic [1:0]  k0;
    logic [31:0] d0;
    logic [3:0]  s0;
    e = expect_rsp(k, a);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin ab[p] = acc_cnt[p]; rb[p] = rsp_cnt[p]; end
    check(rdcmd_ready == 1'b1, "R1 idle ready", 64'(rdcmd_ready), 64'd1);
    rdcmd_valid = 1'b1; rdcmd_kind = k; rdcmd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rdcmd_valid = 1'b0; rdcmd_kind = 3'($urandom); rdcmd_addr = 8'($urandom);
    check(rdcmd_ready == 1'b0, "R1 busy after accept", 64'(rdcmd_ready), 64'd0);
    while (!rdrsp_valid) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check(acc_cnt[p] - ab[p] == int'(e[38]), "R8 probes accepted (R4/R5/R6/R7)",
            64'(acc_cnt[p] - ab[p]), 64'(e[38]));
      check(rsp_cnt[p] - rb[p] == int'(e[38]), "R8 completions before response",
            64'(rsp_cnt[p] - rb[p]), 64'(e[38]));
    end
    check(rdrsp_kind == e[37:36], "R2 response kind", 64'(rdrsp_kind), 64'(e[37:36]));
    check(rdrsp_status == e[35:32], "R3/R4 status (R12 bits)", 64'(rdrsp_status), 64'(e[35:32]));
    check(rdrsp_data == e[31:0], "R12 line data (R3 R5 R6 R7)", 64'(rdrsp_data), 64'(e[31:0]));
    check(rdack_ready && (&prbrsp_ready), "R11 side streams ready", 64'({rdack_ready, prbrsp_ready}), 64'('1));
    k0 = rdrsp_kind; d0 = rdrsp_data; s0 = rdrsp_status;
    stable_ok = 1'b1;
    for (int i = 0; i < rwait; i++) begin
      @(negedge clk);
      if (!rdrsp_valid || rdrsp_kind != k0 || rdrsp_data != d0 || rdrsp_status != s0) stable_ok = 1'b0;
    end
    if (rwait > 0) check(stable_ok, "R9 response held", 64'(stable_ok), 64'd1);
    rdrsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdrsp_ready = 1'b0;
    check(!rdrsp_valid && !rdcmd_ready, "R10 await ack", 64'({rdrsp_valid, rdcmd_ready}), 64'd0);
    lock_ok = 1'b1;
    rdcmd_valid = 1'b1;
    for (int i = 0; i < await_n; i++) begin
      @(negedge clk);
      if (rdcmd_ready) lock_ok = 1'b0;
    end
    rdcmd_valid = 1'b0;
    check(lock_ok, "R10 locked until ack", 64'(lock_ok), 64'd1);
    rdack_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdack_valid = 1'b0;
    check(rdcmd_ready && !rdrsp_valid, "R10 idle after ack", 64'({rdcmd_ready, rdrsp_valid}), 64'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(rdcmd_ready == 1'b1, "R1 reset ready", 64'(rdcmd_ready), 64'd1);
    check(!rdrsp_valid && prbcmd_valid == '0, "R1 reset valids", 64'({rdrsp_valid, prbcmd_valid}), 64'd0);
    check(rdack_ready && (&prbrsp_ready), "R11 after reset", 64'({rdack_ready, prbrsp_ready}), 64'('1));

    // directed corners
    run_tx(3'd0, 8'h40, 2, 1);   // R3 low edge
    run_tx(3'd2, 8'h5F, 0, 0);   // R3 high edge, one-time read
    run_tx(3'd0, 8'h3F, 1, 0);   // R7 below window
    run_tx(3'd1, 8'h60, 0, 2);   // R7 unique above window, no probe
    run_tx(3'd1, 8'h4A, 3, 1);   // R4
    run_tx(3'd3, 8'h10, 1, 0);   // R5 make-unique outside window
    run_tx(3'd4, 8'h45, 0, 0);   // R6
    run_tx(3'd5, 8'h41, 0, 0);   // R7 unknown
    run_tx(3'd7, 8'h41, 0, 0);   // R7 unknown

    // R10 stray acknowledge while idle
    @(negedge clk);
    rdack_valid = 1'b1;
    @(negedge clk);
    rdack_valid = 1'b0;
    check(rdcmd_ready && !rdrsp_valid, "R10 stray ack ignored", 64'({rdcmd_ready, rdrsp_valid}), 64'b10);

    // R8 stray completion while idle, then a probed request must still wait
    stray_req = 1'b1;
    repeat (2) @(negedge clk);
    stray_req = 1'b0;
    check(prbcmd_valid == '0 && !rdrsp_valid, "R8 stray completion ignored", 64'({prbcmd_valid, rdrsp_valid}), 64'd0);
    run_tx(3'd3, 8'h50, 0, 0);

    // random mix
    for (int n = 0; n < 80; n++) begin
      run_tx(3'($urandom % 8), 8'(8'h30 + ($urandom % 8'h40)), $urandom % 4, $urandom % 3);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule